// File: doc/BRIEF.md
# Segmented Address Decoder with Write Isolation

This block sits between a 32-bit processor's load/store unit and the memory regions behind it. Each request brings an address, a read/write strobe, a size code and write data. The block works out which of five regions the request targets: main RAM, parallel-port space, scratchpad, hardware registers or boot ROM. It returns a one-hot select, the byte offset inside that region, and an error flag when no region answers. The cached and uncached segment mirrors fold onto the physical map. Main RAM repeats inside its 8 MB window.

The block also holds a single cache-control word at a fixed address. Writing particular values to it turns an isolation mode on or off. While that mode is on, stores aimed at RAM through any alias are dropped. Every RAM store that does go through raises a one-cycle invalidate pulse. The pulse carries the word-aligned address, so that cached copies of code can be discarded.

All decoded results are registered. They appear one clock after the request.

Top module: `seg_addr_decoder`

## Requirements
- R1: A request accepted on a clock edge with `req_valid` high shows `out_valid` high after that edge. `out_sel` is one-hot: bit 0 is RAM, bit 1 is parallel port, bit 2 is scratchpad, bit 3 is hardware registers and bit 4 is boot ROM. With no request, `out_valid`, `out_sel`, `out_err` and `inv_valid` are all low.
- R2: Pages 0x0000 to 0x007F (the upper 16 address bits) select RAM. The offset is {page[4:0], addr[15:0]}, so the 2 MB of RAM repeats four times.
- R3: Pages whose top three bits are 100 or 101 fold onto the physical page with those three bits cleared. This gives mirrors at 0x8000–0x807F, 0xA000–0x007F+0xA000, 0x9F80, 0xBF80, 0x9FC0–0x9FC7 and 0xBFC0–0xBFC7. Each mirror decodes exactly like its physical page.
- R4: Page 0x1F00 selects the parallel port with offset addr[15:0]. That page has no mirror, so 0x9F00 and 0xBF00 are unmapped.
- R5: Physical page 0x1F80 selects the scratchpad when addr[15:0] < 0x400, and the hardware registers otherwise. The offset is addr[15:0] in both cases.
- R6: Physical pages 0x1FC0 to 0x1FC7 select boot ROM on reads, with offset {page[2:0], addr[15:0]}. A write there selects nothing and raises `out_err`.
- R7: Any other address, apart from the control word, raises `out_err`, selects nothing and returns `out_rdata` = 0.
- R8: A word write (size code 2) of 0x800 or 0x804 to address 0xFFFE0130 sets `iso_mode`. The change is visible after that edge.
- R9: While `iso_mode` is set, a write that decodes to RAM (any alias) selects nothing, raises no error and emits no invalidate. Reads of RAM still select it.
- R10: A word write of 0x0 or 0x1E988 to the control address clears `iso_mode`. A request for the state already held leaves the mode unchanged.
- R11: A control write of any other value, or of a size other than word, raises `out_unk` and leaves `iso_mode` unchanged. A word write of any value updates the stored control word; a non-word write does not. A read of the control address returns the stored word, which is zero after reset.
- R12: Each RAM write not blocked by isolation raises `inv_valid` in the same cycle as `out_sel[0]`. `inv_addr` is the request address with bits 1:0 cleared.
- R13: The size code passes through to `out_size` unchanged. Unaligned halfword and word accesses decode like any other access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 32 | Request address |
| req_wdata | input | 32 | Store data (used by the control word) |
| out_valid | output | 1 | Registered request marker |
| out_sel | output | 5 | One-hot region select |
| out_off | output | 21 | Byte offset inside the selected region |
| out_err | output | 1 | Unmapped access, or write to ROM |
| out_unk | output | 1 | Unrecognised control write |
| out_size | output | 2 | Registered size code |
| out_rdata | output | 32 | Control word readback, zero otherwise |
| inv_valid | output | 1 | Code-invalidate pulse |
| inv_addr | output | 32 | Word-aligned address of the invalidate |
| iso_mode | output | 1 | Isolation mode state |

## Verification
The isolation update and a RAM store decode can land on consecutive edges. A store that follows a control write directly must see the new mode. The bench issues a control write and then a RAM store through an uncached mirror with `req_valid` held high. It judges that store against the mode already changed: no select and no invalidate after entry, and select plus invalidate straight after exit. Full-page sweeps of reads, and sampled sweeps of writes in both modes, are compared against an arithmetic map model.

// File: rtl/seg_dec_pkg.sv
package seg_dec_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   localparam int RGN_N    = 5;
   localparam int RGN_RAM  = 0;
   localparam int RGN_PAR  = 1;
   localparam int RGN_SPAD = 2;
   localparam int RGN_HW   = 3;
   localparam int RGN_ROM  = 4;

   localparam int SEG_BITS = 3;

endpackage

// File: rtl/seg_page_classify.sv
module seg_page_classify
   import seg_dec_pkg::*;
#(
   parameter int ADDR_W           = 32,
   parameter int PAGE_BITS        = 16,
   parameter int RAM_WINDOW_PAGES = 128,
   parameter int RAM_PAGES        = 32,
   parameter int PAR_PAGE         = 'h1F00,
   parameter int IO_PAGE          = 'h1F80,
   parameter int SPAD_BYTES       = 1024,
   parameter int ROM_BASE_PAGE    = 'h1FC0,
   parameter int ROM_PAGES        = 8,
   parameter bit FOLD_MIRRORS     = 1'b1,
   parameter logic [ADDR_W-1:0] CTL_ADDR = 32'hFFFE0130,
   parameter int OFF_W            = 21
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              is_write,
   output logic [RGN_N-1:0]  sel,
   output logic [OFF_W-1:0]  off,
   output logic              err,
   output logic              ram_hit,
   output logic              ctl_hit
);
   localparam int PAGE_W    = ADDR_W - PAGE_BITS;
   localparam int RAM_IDX_W = $clog2(RAM_PAGES);
   localparam int ROM_IDX_W = $clog2(ROM_PAGES);

   logic [PAGE_W-1:0]    page;
   logic [PAGE_W-1:0]    phys;
   logic [PAGE_BITS-1:0] low;
   logic [SEG_BITS-1:0]  seg;
   logic                 direct, folded, in_map;
   logic                 par_in, io_in, spad_in, hw_in, rom_in;

   assign page   = addr[ADDR_W-1:PAGE_BITS];
   assign low    = addr[PAGE_BITS-1:0];
   assign seg    = page[PAGE_W-1 -: SEG_BITS];
   assign phys   = {{SEG_BITS{1'b0}}, page[PAGE_W-SEG_BITS-1:0]};
   assign direct = (seg == '0);

   generate
      if (FOLD_MIRRORS) begin : g_fold
         assign folded = (seg == 3'b100) || (seg == 3'b101);
      end else begin : g_nofold
         assign folded = 1'b0;
      end
   endgenerate

   assign in_map  = direct || folded;
   assign ram_hit = in_map && (phys < PAGE_W'(RAM_WINDOW_PAGES));
   assign par_in  = direct && (page == PAGE_W'(PAR_PAGE));
   assign io_in   = in_map && (phys == PAGE_W'(IO_PAGE));
   assign spad_in = io_in && ({1'b0, low} < (PAGE_BITS+1)'(SPAD_BYTES));
   assign hw_in   = io_in && !spad_in;
   assign rom_in  = in_map && (phys >= PAGE_W'(ROM_BASE_PAGE))
                           && (phys <  PAGE_W'(ROM_BASE_PAGE + ROM_PAGES));
   assign ctl_hit = (addr == CTL_ADDR);

   always_comb begin
      sel           = '0;
      sel[RGN_RAM]  = ram_hit;
      sel[RGN_PAR]  = par_in;
      sel[RGN_SPAD] = spad_in;
      sel[RGN_HW]   = hw_in;
      sel[RGN_ROM]  = rom_in && !is_write;
      err = (!(ram_hit || par_in || io_in || rom_in) && !ctl_hit)
            || (rom_in && is_write);
      if (ram_hit)
         off = OFF_W'({phys[RAM_IDX_W-1:0], low});
      else if (rom_in)
         off = OFF_W'({phys[ROM_IDX_W-1:0], low});
      else if (par_in || io_in)
         off = OFF_W'(low);
      else
         off = '0;
   end

endmodule

// File: rtl/seg_iso_ctl.sv
module seg_iso_ctl #(
   parameter int DATA_W = 32,
   parameter logic [DATA_W-1:0] ON_A  = 32'h0000_0800,
   parameter logic [DATA_W-1:0] ON_B  = 32'h0000_0804,
   parameter logic [DATA_W-1:0] OFF_A = 32'h0000_0000,
   parameter logic [DATA_W-1:0] OFF_B = 32'h0001_E988
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_word,
   input  logic [DATA_W-1:0] wdata,
   output logic              iso_q,
   output logic [DATA_W-1:0] ctl_q,
   output logic              unk
);
   logic val_on, val_off;

   assign val_on  = (wdata == ON_A)  || (wdata == ON_B);
   assign val_off = (wdata == OFF_A) || (wdata == OFF_B);
   assign unk     = wr_en && (!wr_word || !(val_on || val_off));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         iso_q <= 1'b0;
         ctl_q <= '0;
      end else if (wr_en && wr_word) begin
         ctl_q <= wdata;
         if (val_on)
            iso_q <= 1'b1;
         else if (val_off)
            iso_q <= 1'b0;
      end
   end

endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage
   import seg_dec_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int OFF_W  = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [RGN_N-1:0]  in_sel,
   input  logic [OFF_W-1:0]  in_off,
   input  logic              in_err,
   input  logic              in_unk,
   input  logic [1:0]        in_size,
   input  logic [DATA_W-1:0] in_rdata,
   input  logic              in_inv,
   input  logic [ADDR_W-1:0] in_inv_addr,
   output logic              q_valid,
   output logic [RGN_N-1:0]  q_sel,
   output logic [OFF_W-1:0]  q_off,
   output logic              q_err,
   output logic              q_unk,
   output logic [1:0]        q_size,
   output logic [DATA_W-1:0] q_rdata,
   output logic              q_inv,
   output logic [ADDR_W-1:0] q_inv_addr
);
   always_ff @(posedge clk) begin
      if (!rst_n || !in_valid) begin
         q_valid    <= 1'b0;
         q_sel      <= '0;
         q_off      <= '0;
         q_err      <= 1'b0;
         q_unk      <= 1'b0;
         q_size     <= '0;
         q_rdata    <= '0;
         q_inv      <= 1'b0;
         q_inv_addr <= '0;
      end else begin
         q_valid    <= 1'b1;
         q_sel      <= in_sel;
         q_off      <= in_off;
         q_err      <= in_err;
         q_unk      <= in_unk;
         q_size     <= in_size;
         q_rdata    <= in_rdata;
         q_inv      <= in_inv;
         q_inv_addr <= in_inv ? in_inv_addr : '0;
      end
   end

endmodule

// File: rtl/seg_addr_decoder.sv
module seg_addr_decoder
   import seg_dec_pkg::*;
#(
   parameter int ADDR_W           = 32,
   parameter int DATA_W           = 32,
   parameter int PAGE_BITS        = 16,
   parameter int RAM_WINDOW_PAGES = 128,
   parameter int RAM_PAGES        = 32,
   parameter int PAR_PAGE         = 'h1F00,
   parameter int IO_PAGE          = 'h1F80,
   parameter int SPAD_BYTES       = 1024,
   parameter int ROM_BASE_PAGE    = 'h1FC0,
   parameter int ROM_PAGES        = 8,
   parameter bit FOLD_MIRRORS     = 1'b1,
   parameter logic [ADDR_W-1:0] CTL_ADDR = 32'hFFFE0130,
   localparam int RAM_IDX_W = $clog2(RAM_PAGES),
   localparam int ROM_IDX_W = $clog2(ROM_PAGES),
   localparam int OFF_W     = PAGE_BITS + ((RAM_IDX_W > ROM_IDX_W) ? RAM_IDX_W : ROM_IDX_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              out_valid,
   output logic [RGN_N-1:0]  out_sel,
   output logic [OFF_W-1:0]  out_off,
   output logic              out_err,
   output logic              out_unk,
   output logic [1:0]        out_size,
   output logic [DATA_W-1:0] out_rdata,
   output logic              inv_valid,
   output logic [ADDR_W-1:0] inv_addr,
   output logic              iso_mode
);
   generate
      if (ADDR_W - PAGE_BITS <= SEG_BITS) begin : g_bad_page
         $error("page field too narrow for segment folding");
      end
      if (RAM_PAGES < 2 || (RAM_PAGES & (RAM_PAGES - 1)) != 0
          || RAM_PAGES > RAM_WINDOW_PAGES) begin : g_bad_ram
         $error("RAM_PAGES must be a power of two within the RAM window");
      end
      if (ROM_PAGES < 2 || (ROM_PAGES & (ROM_PAGES - 1)) != 0
          || (ROM_BASE_PAGE % ROM_PAGES) != 0) begin : g_bad_rom
         $error("ROM_PAGES must be a power of two and divide ROM_BASE_PAGE");
      end
      if (SPAD_BYTES < 1 || SPAD_BYTES > (1 << PAGE_BITS)) begin : g_bad_spad
         $error("SPAD_BYTES must fit in one page");
      end
   endgenerate

   logic [RGN_N-1:0]  dec_sel, eff_sel;
   logic [OFF_W-1:0]  dec_off;
   logic              dec_err, ram_hit, ctl_hit;
   logic              ctl_wr, ctl_unk, wr_blocked, ram_wr_ok;
   logic [DATA_W-1:0] ctl_q, rdata_d;

   seg_page_classify #(
      .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
      .RAM_WINDOW_PAGES(RAM_WINDOW_PAGES), .RAM_PAGES(RAM_PAGES),
      .PAR_PAGE(PAR_PAGE), .IO_PAGE(IO_PAGE), .SPAD_BYTES(SPAD_BYTES),
      .ROM_BASE_PAGE(ROM_BASE_PAGE), .ROM_PAGES(ROM_PAGES),
      .FOLD_MIRRORS(FOLD_MIRRORS), .CTL_ADDR(CTL_ADDR), .OFF_W(OFF_W)
   ) u_classify (
      .addr(req_addr), .is_write(req_write),
      .sel(dec_sel), .off(dec_off), .err(dec_err),
      .ram_hit(ram_hit), .ctl_hit(ctl_hit)
   );

   assign ctl_wr = req_valid && req_write && ctl_hit;

   seg_iso_ctl #(.DATA_W(DATA_W)) u_iso (
      .clk(clk), .rst_n(rst_n),
      .wr_en(ctl_wr), .wr_word(req_size == 2'(SZ_WORD)),
      .wdata(req_wdata),
      .iso_q(iso_mode), .ctl_q(ctl_q), .unk(ctl_unk)
   );

   assign wr_blocked = req_write && ram_hit && iso_mode;
   assign ram_wr_ok  = req_write && ram_hit && !iso_mode;

   always_comb begin
      eff_sel          = dec_sel;
      eff_sel[RGN_RAM] = dec_sel[RGN_RAM] && !wr_blocked;
   end

   assign rdata_d = (!req_write && ctl_hit) ? ctl_q : '0;

   seg_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W)) u_out (
      .clk(clk), .rst_n(rst_n),
      .in_valid(req_valid), .in_sel(eff_sel), .in_off(dec_off),
      .in_err(dec_err), .in_unk(ctl_unk), .in_size(req_size),
      .in_rdata(rdata_d), .in_inv(ram_wr_ok),
      .in_inv_addr({req_addr[ADDR_W-1:2], 2'b00}),
      .q_valid(out_valid), .q_sel(out_sel), .q_off(out_off),
      .q_err(out_err), .q_unk(out_unk), .q_size(out_size),
      .q_rdata(out_rdata), .q_inv(inv_valid), .q_inv_addr(inv_addr)
   );

endmodule

// File: rtl/seg_addr_decoder_chk.sv
module seg_addr_decoder_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [1:0]        req_size,
   input logic              out_valid,
   input logic [4:0]        out_sel,
   input logic              out_err,
   input logic [1:0]        out_size,
   input logic              inv_valid,
   input logic [1:0]        inv_lo,
   input logic              iso_mode
);
   // R1: select is one-hot or empty
   p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_sel));

   // R1: a request shows up one cycle later
   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> out_valid);

   // R1: idle cycles leave every output strobe low
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!out_valid && out_sel == 5'd0 && !out_err && !inv_valid));

   // R7: an error never comes with a select
   p_err_nosel_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> (out_sel == 5'd0));

   // R6: a store never selects ROM
   p_rom_noread_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> !out_sel[4]);

   // R9: no invalidate for a store made while isolated
   p_iso_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> !$past(iso_mode));

   // R12: the invalidate rides with a RAM select on an aligned word
   p_inv_ram_r12: assert property (@(posedge clk) disable iff (!rst_n)
      inv_valid |-> (out_sel[0] && inv_lo == 2'b00));

   // R10: only a store can move the isolation mode
   p_iso_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid || !req_write) |=> $stable(iso_mode));

   // R13: size code passes through unchanged
   p_size_pass_r13: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (out_size == $past(req_size)));

endmodule

bind seg_addr_decoder seg_addr_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_size(req_size), .out_valid(out_valid), .out_sel(out_sel),
   .out_err(out_err), .out_size(out_size), .inv_valid(inv_valid),
   .inv_lo(inv_addr[1:0]), .iso_mode(iso_mode)
);

// File: tb/seg_addr_decoder_test.sv
`timescale 1ns/1ps
module seg_addr_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic        out_valid, out_err, out_unk, inv_valid, iso_mode;
   logic [4:0]  out_sel;
   logic [20:0] out_off;
   logic [1:0]  out_size;
   logic [31:0] out_rdata, inv_addr;

   int checks = 0, errors = 0;
   bit iso_s = 1'b0;
   logic [31:0] ctl_s = '0;

   always #4 clk = ~clk;

   seg_addr_decoder uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
      .out_valid(out_valid), .out_sel(out_sel), .out_off(out_off),
      .out_err(out_err), .out_unk(out_unk), .out_size(out_size),
      .out_rdata(out_rdata), .inv_valid(inv_valid), .inv_addr(inv_addr),
      .iso_mode(iso_mode)
   );

   // Expected decode computed from the written map rules
   task automatic model(input logic [31:0] a, input bit w, input logic [1:0] sz,
                        input logic [31:0] d,
                        output logic [4:0] s, output logic [20:0] o,
                        output bit e, output bit inv, output bit unk,
                        output logic [31:0] rd, output string tag);
      logic [15:0] pg, lo, ph;
      logic [2:0]  sg;
      bit inmap;
      pg = a[31:16]; lo = a[15:0]; sg = pg[15:13];
      ph = {3'b000, pg[12:0]};
      inmap = (sg == 3'd0) || (sg == 3'd4) || (sg == 3'd5);
      s = '0; o = '0; e = 0; inv = 0; unk = 0; rd = '0;
      tag = (sg != 3'd0 && inmap) ? "R3" : "R7";
      if (inmap && ph < 16'h0080) begin
         o = {ph[4:0], lo};
         if (sg == 3'd0) tag = "R2";
         if (w && iso_s) tag = "R9";
         else begin s = 5'b00001; inv = w; if (w) tag = "R12"; end
      end else if (sg == 3'd0 && pg == 16'h1F00) begin
         s = 5'b00010; o = {5'd0, lo}; tag = "R4";
      end else if (inmap && ph == 16'h1F80) begin
         s = (lo < 16'h0400) ? 5'b00100 : 5'b01000; o = {5'd0, lo};
         if (sg == 3'd0) tag = "R5";
      end else if (inmap && ph >= 16'h1FC0 && ph < 16'h1FC8) begin
         if (w) begin e = 1; tag = "R6"; end
         else begin s = 5'b10000; o = {2'd0, ph[2:0], lo}; if (sg == 3'd0) tag = "R6"; end
      end else if (a == 32'hFFFE0130) begin
         tag = "R11";
         if (w) unk = !(sz == 2'd2 && (d == 32'h800 || d == 32'h804 ||
                                       d == 32'h0 || d == 32'h1E988));
         else rd = ctl_s;
      end else begin
         e = 1;
      end
   endtask

   task automatic fail(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
   endtask

   task automatic do_req(input bit w, input logic [1:0] sz, input logic [31:0] a,
                         input logic [31:0] d);
      logic [4:0] s; logic [20:0] o; bit e, inv, unk; logic [31:0] rd;
      string tag; bit bad;
      model(a, w, sz, d, s, o, e, inv, unk, rd, tag);
      @(negedge clk);
      req_valid = 1'b1; req_write = w; req_size = sz; req_addr = a; req_wdata = d;
      @(posedge clk);
      // bench shadow of the control word and mode after this edge
      if (w && a == 32'hFFFE0130 && sz == 2'd2) begin
         ctl_s = d;
         if (d == 32'h800 || d == 32'h804) iso_s = 1'b1;
         else if (d == 32'h0 || d == 32'h1E988) iso_s = 1'b0;
      end
      #1;
      checks++;
      bad = 0;
      if (out_valid !== 1'b1) begin fail("R1", "valid", out_valid, 1); bad = 1; end
      if (!bad && out_sel !== s) begin fail(tag, "sel", out_sel, s); bad = 1; end
      if (!bad && s != 0 && out_off !== o) begin fail(tag, "off", out_off, o); bad = 1; end
      if (!bad && out_err !== e) begin fail(tag, "err", out_err, e); bad = 1; end
      if (!bad && inv_valid !== inv) begin fail(tag, "inv", inv_valid, inv); bad = 1; end
      if (!bad && inv && inv_addr !== {a[31:2], 2'b00})
         begin fail("R12", "inv_addr", inv_addr, {a[31:2], 2'b00}); bad = 1; end
      if (!bad && out_unk !== unk) begin fail("R11", "unk", out_unk, unk); bad = 1; end
      if (!bad && out_rdata !== rd) begin fail(tag, "rdata", out_rdata, rd); bad = 1; end
      if (!bad && out_size !== sz) begin fail("R13", "size", out_size, sz); bad = 1; end
      if (!bad && iso_mode !== iso_s) begin fail("R8", "iso_mode", iso_mode, iso_s); bad = 1; end
   endtask

   task automatic idle_check();
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      @(posedge clk); #1;
      checks++;
      if (out_valid !== 1'b0 || out_sel !== 5'd0 || inv_valid !== 1'b0)
         fail("R1", "idle", {out_valid, out_sel, inv_valid}, 0);
   endtask

   initial begin
      #(8 * 190000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if (out_valid !== 1'b0 || out_sel !== 5'd0 || iso_mode !== 1'b0)
         fail("R1", "reset state", {out_valid, out_sel, iso_mode}, 0);
      @(negedge clk); rst_n = 1'b1;

      // Control word reads as zero after reset (R11)
      do_req(0, 2'd2, 32'hFFFE0130, 0);

      // Read sweep over every page, mixing the low half (R2..R7)
      for (int p = 0; p < 65536; p++) begin
         logic [15:0] lo;
         lo = 16'(p * 16'h9E37);
         do_req(0, 2'(p % 3), {16'(p), lo}, 0);
      end

      // Directed boundaries
      do_req(0, 2'd2, 32'h0000_0010, 0);   // R2
      do_req(0, 2'd2, 32'h0060_0010, 0);   // R2 fourth repeat
      do_req(0, 2'd0, 32'hA07F_FFFF, 0);   // R3
      do_req(0, 2'd0, 32'h1F80_03FF, 0);   // R5 scratchpad end
      do_req(0, 2'd0, 32'h1F80_0400, 0);   // R5 registers start
      do_req(0, 2'd2, 32'hBF80_03FC, 0);   // R5 via mirror, R3
      do_req(0, 2'd0, 32'h9F00_0000, 0);   // R4 no parallel mirror
      do_req(0, 2'd2, 32'h1FC7_FFFC, 0);   // R6
      do_req(1, 2'd2, 32'hBFC0_0000, 32'h1); // R6 write to ROM
      do_req(0, 2'd2, 32'h0080_0000, 0);   // R7

      // Write sweep, not isolated (R12)
      for (int p = 0; p < 65536; p += 61)
         do_req(1, 2'd2, {16'(p), 16'(p * 7)}, 32'hDEAD);

      // Enter isolation then store at once through a mirror (R8, R9)
      do_req(1, 2'd2, 32'hFFFE0130, 32'h800);
      do_req(1, 2'd2, 32'hA000_1234, 32'h5);
      do_req(0, 2'd2, 32'h8000_1234, 0);   // R9 reads still select
      do_req(1, 2'd2, 32'hFFFE0130, 32'h804); // R10 already set
      do_req(1, 2'd2, 32'hFFFE0130, 32'h12345); // R11 unknown value
      do_req(0, 2'd2, 32'hFFFE0130, 0);    // R11 readback
      do_req(1, 2'd0, 32'hFFFE0130, 32'h0);  // R11 byte write ignored
      do_req(0, 2'd2, 32'hFFFE0130, 0);

      // Write sweep while isolated (R9)
      for (int p = 0; p < 65536; p += 67)
         do_req(1, 2'(p % 3), {16'(p), 16'(p * 5)}, 32'h77);

      // Leave isolation and store at once (R10, R12)
      do_req(1, 2'd2, 32'hFFFE0130, 32'h1E988);
      do_req(1, 2'd1, 32'h8000_0003, 32'h9);  // R13 unaligned halfword
      do_req(1, 2'd2, 32'hFFFE0130, 32'h0);   // R10 already clear
      do_req(1, 2'd2, 32'h001F_FFFE, 32'h1);  // R13 unaligned word
      do_req(1, 2'd2, 32'hFFFE0130, 32'h804);
      do_req(1, 2'd2, 32'hFFFE0130, 32'h0);
      do_req(0, 2'd2, 32'hFFFE0130, 0);

      idle_check();
      idle_check();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule